// File: doc/BRIEF.md
# Parallel Static Memory Controller

This block connects an on-chip requester to an external parallel memory: ROM, SRAM or NOR flash. The requester can ask for three things: a single random read, a burst of sequential reads that uses page mode, or a single write. It makes each request through a valid/ready handshake. The controller drives the address, an active-low output enable and an active-low write strobe. It drives or releases a bidirectional data bus, and it hands read words back one per beat with a last-beat flag.

Every timing interval is a programmable count of system clocks, so the same block fits memories of different speeds:

- The random access time is set by `cfg_rand`.
- The page access time is set by `cfg_page`.
- The idle gap during which the data bus is released is set by `cfg_float`.

The bus is 16 bits wide, or 8 bits wide when `cfg_wide` is low. In 8-bit mode each 16-bit request becomes two byte accesses, lower byte first. A high-impedance request input, active low, floats every memory-side line so that another master can use the bus.

Requests are word addressed. In 16-bit mode the bus address equals the word address. In 8-bit mode the bus address is the word address shifted left by one, with the byte select in bit 0. A page is the set of bus addresses that agree in every bit above the lowest `PAGE_BITS` (default 2). The configuration inputs are expected to change only while the block is idle.

Top module: `smem_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rd_valid` is 0, and both `mem_oe_n` and `mem_we_n` are 1.
- R2: A read is accepted on the clock edge where `req_valid` and `req_ready` are both high. Call the cycle after that edge cycle 0. The first bus access then holds its address with `mem_oe_n` low for R = `cfg_rand`+1 cycles. The data bus is sampled at the edge that ends cycle R-1, and `rd_valid` is 1 in cycle R.
- R3: In a burst of `req_len`+1 words, `mem_oe_n` stays low from the first access to the last. Each later access whose bus address stays inside the previous access's page lasts P = `cfg_page`+1 cycles. `rd_data` delivers the words in order, and `rd_last` marks the final word.
- R4: A burst access whose bus address leaves the previous access's page lasts R cycles instead of P.
- R5: After the last read access, or after the hold cycle of a write, the block waits F = `cfg_float`+1 cycles with both strobes high and the data bus released. `req_ready` returns to 1 in the cycle after that gap.
- R6: A write holds `mem_we_n` low for R cycles, with `mem_oe_n` high and the write data driven. It then spends one cycle with `mem_we_n` high while the address and the data are still driven.
- R7: With `cfg_wide` at 0, each word becomes two byte accesses on `mem_data[7:0]`: first at bus address 2·word, carrying the low byte, then at 2·word+1, carrying the high byte. A read returns {second byte, first byte}. A write performs two complete write cycles, each followed by the float gap.
- R8: While `hiz_n` is 0, `mem_addr`, `mem_oe_n`, `mem_we_n` and `mem_data` are not driven by the block.
- R9: The address does not change while `mem_we_n` is low, nor in the cycle after it rises. During a read, `mem_addr` shows the current access's bus address and keeps the last one through the float gap.
- R10: `req_ready` is 1 only while the block is idle. It is 0 from the cycle after acceptance until the request has fully completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_float | input | 2 | Float gap count minus one |
| cfg_rand | input | 4 | Random access count minus one |
| cfg_page | input | 3 | Page access count minus one |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Word address |
| req_len | input | 4 | Burst words minus one (reads only) |
| req_wdata | input | 16 | Write word |
| rd_valid | output | 1 | Read word valid, one cycle |
| rd_data | output | 16 | Read word |
| rd_last | output | 1 | Final word of the burst |
| hiz_n | input | 1 | 0 = float all memory-side lines |
| mem_addr | inout | 26 | Memory address, tri-state |
| mem_oe_n | inout | 1 | Output enable, active low, tri-state |
| mem_we_n | inout | 1 | Write strobe, active low, tri-state |
| mem_data | inout | 16 | Memory data |

## Verification
The hardest situation to reach is a burst whose page-mode run is broken partway through, especially in 8-bit mode, where two bytes of one word share a page but the next word may not. A second hard case is a setting where the page time is longer than the random time, so that an access of the wrong kind is shorter as well as longer than expected. The stimulus starts bursts just below a page boundary in both bus widths and runs them under several count settings, including R=1 with P=4. The memory model returns a garbage word until the programmed delay for the current access kind has passed, so a data sample taken one cycle early shows up as bad data as well as bad timing.

// File: rtl/smem_ctrl.sv
module smem_ctrl #(
  parameter int AW        = 26,
  parameter int DW        = 16,
  parameter int PAGE_BITS = 2,
  parameter int LEN_BITS  = 4,
  parameter int CW        = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wide,
  input  logic [1:0]          cfg_float,
  input  logic [CW-1:0]       cfg_rand,
  input  logic [2:0]          cfg_page,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [LEN_BITS-1:0] req_len,
  input  logic [DW-1:0]       req_wdata,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic                rd_last,
  input  logic                hiz_n,
  inout  wire  [AW-1:0]       mem_addr,
  inout  wire                 mem_oe_n,
  inout  wire                 mem_we_n,
  inout  wire  [DW-1:0]       mem_data
);
  localparam int BW = DW / 2;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_WH, S_GAP} st_t;

  st_t                 st_q;
  logic [AW-1:0]       addr_q, word_q;
  logic [LEN_BITS-1:0] beats_q;
  logic                byte_q, pend_q, oe_q, we_q, drv_q;
  logic [DW-1:0]       wout_q, wword_q;
  logic [BW-1:0]       lo_q;
  logic [CW-1:0]       cnt_q;

  function automatic logic [AW-1:0] bus_addr(input logic [AW-1:0] w, input logic b, input logic wide);
    return wide ? w : {w[AW-2:0], b};
  endfunction

  wire [CW-1:0] r_ld      = cfg_rand;
  wire [CW-1:0] p_ld      = CW'(cfg_page);
  wire [CW-1:0] f_ld      = CW'(cfg_float);
  wire          cnt_done  = (cnt_q == '0);
  wire          nxt_same  = !cfg_wide && !byte_q;
  wire [AW-1:0] nxt_word  = nxt_same ? word_q : word_q + AW'(1);
  wire [AW-1:0] nxt_addr  = bus_addr(nxt_word, nxt_same, cfg_wide);
  wire          word_done = cfg_wide || byte_q;
  wire          last_acc  = (beats_q == '0) && word_done;
  wire          in_page   = (nxt_addr[AW-1:PAGE_BITS] == addr_q[AW-1:PAGE_BITS]);
  wire [DW-1:0] word_in   = cfg_wide ? mem_data : {mem_data[BW-1:0], lo_q};

  assign req_ready = (st_q == S_IDLE);
  assign mem_addr  = hiz_n ? addr_q : {AW{1'bz}};
  assign mem_oe_n  = hiz_n ? oe_q : 1'bz;
  assign mem_we_n  = hiz_n ? we_q : 1'bz;
  assign mem_data  = (hiz_n && drv_q) ? wout_q : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      addr_q   <= '0;
      word_q   <= '0;
      beats_q  <= '0;
      byte_q   <= 1'b0;
      pend_q   <= 1'b0;
      oe_q     <= 1'b1;
      we_q     <= 1'b1;
      drv_q    <= 1'b0;
      wout_q   <= '0;
      wword_q  <= '0;
      lo_q     <= '0;
      cnt_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          word_q  <= req_addr;
          byte_q  <= 1'b0;
          beats_q <= req_len;
          addr_q  <= bus_addr(req_addr, 1'b0, cfg_wide);
          cnt_q   <= r_ld;
          if (req_write) begin
            we_q    <= 1'b0;
            drv_q   <= 1'b1;
            wword_q <= req_wdata;
            wout_q  <= cfg_wide ? req_wdata : {{BW{1'b0}}, req_wdata[BW-1:0]};
            pend_q  <= !cfg_wide;
            st_q    <= S_WR;
          end else begin
            oe_q <= 1'b0;
            st_q <= S_RD;
          end
        end
        S_RD: if (cnt_done) begin
          if (nxt_same) lo_q <= mem_data[BW-1:0];
          if (word_done) begin
            rd_valid <= 1'b1;
            rd_data  <= word_in;
            rd_last  <= (beats_q == '0);
          end
          if (last_acc) begin
            oe_q  <= 1'b1;
            cnt_q <= f_ld;
            st_q  <= S_GAP;
          end else begin
            addr_q <= nxt_addr;
            word_q <= nxt_word;
            byte_q <= nxt_same;
            if (word_done) beats_q <= beats_q - LEN_BITS'(1);
            cnt_q  <= in_page ? p_ld : r_ld;
          end
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
        S_WR: if (cnt_done) begin
          we_q <= 1'b1;
          st_q <= S_WH;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
        S_WH: begin
          drv_q <= 1'b0;
          cnt_q <= f_ld;
          st_q  <= S_GAP;
        end
        S_GAP: if (cnt_done) begin
          if (pend_q) begin
            pend_q <= 1'b0;
            byte_q <= 1'b1;
            addr_q <= bus_addr(word_q, 1'b1, cfg_wide);
            wout_q <= {{BW{1'b0}}, wword_q[DW-1:BW]};
            we_q   <= 1'b0;
            drv_q  <= 1'b1;
            cnt_q  <= r_ld;
            st_q   <= S_WR;
          end else begin
            st_q <= S_IDLE;
          end
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smem_ctrl_chk.sv
module smem_ctrl_chk #(
  parameter int AW = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_q,
  input logic          we_q,
  input logic          drv_q,
  input logic [AW-1:0] addr_q,
  input logic          req_ready,
  input logic          rd_valid
);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_q && !we_q));

  p_we_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_q |=> $stable(addr_q));

  p_we_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_q) |-> drv_q);

  p_oe_release_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> (!drv_q && !req_ready));

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (oe_q && we_q && !drv_q));

  p_valid_after_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!oe_q));
endmodule

bind smem_ctrl smem_ctrl_chk #(.AW(AW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .oe_q      (oe_q),
  .we_q      (we_q),
  .drv_q     (drv_q),
  .addr_q    (addr_q),
  .req_ready (req_ready),
  .rd_valid  (rd_valid)
);

// File: tb/test_smem_ctrl.sv
module test_smem_ctrl;
  localparam int AW = 26;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cfg_wide = 1'b1;
  logic [1:0]    cfg_float = '0;
  logic [3:0]    cfg_rand = '0;
  logic [2:0]    cfg_page = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_len = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rd_valid, rd_last;
  logic [DW-1:0] rd_data;
  logic          hiz_n = 1'b1;
  wire  [AW-1:0] mem_addr;
  wire           mem_oe_n, mem_we_n;
  wire  [DW-1:0] mem_data;

  logic          mdrv = 1'b0, probe = 1'b0;
  logic [DW-1:0] mval = '0;
  assign mem_data = probe ? 16'h3C3C : (mdrv ? mval : {DW{1'bz}});
  assign mem_addr = probe ? 26'h2A5A5A5 : {AW{1'bz}};
  assign mem_oe_n = probe ? 1'b0 : 1'bz;
  assign mem_we_n = probe ? 1'b0 : 1'bz;

  smem_ctrl i_smem_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_float(cfg_float),
    .cfg_rand(cfg_rand), .cfg_page(cfg_page), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last), .hiz_n(hiz_n), .mem_addr(mem_addr),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_data(mem_data)
  );

  int vectors = 0, miscompares = 0;
  int R = 1, P = 1, F = 1;

  logic [15:0] m16 [int];
  logic [7:0]  m8  [int];

  function automatic logic [15:0] rd16(int a);
    if (m16.exists(a)) return m16[a];
    return {a[7:0] ^ 8'hA5, a[7:0]};
  endfunction

  function automatic logic [7:0] rd8(int a);
    if (m8.exists(a)) return m8[a];
    return a[7:0] ^ 8'h5C;
  endfunction

  function automatic logic [15:0] exp_word(int w);
    if (cfg_wide) return rd16(w);
    return {rd8(2 * w + 1), rd8(2 * w)};
  endfunction

  // memory model: data appears only after the programmed access delay
  int          a_age = 0, oe_age = 0;
  logic        pg = 1'b0, poe = 1'b1, pwe = 1'b1;
  logic [AW-1:0] pa = '0;
  always @(negedge clk) begin
    if (!rst_n || !hiz_n) begin
      mdrv = 1'b0;
    end else begin
      if (!pwe && mem_we_n) begin
        if (cfg_wide) m16[int'(mem_addr)] = mem_data;
        else          m8[int'(mem_addr)]  = mem_data[7:0];
      end
      if (mem_addr != pa) begin
        pg = (mem_addr[AW-1:2] == pa[AW-1:2]) && !poe;
        a_age = 1;
      end else begin
        a_age++;
      end
      oe_age = !mem_oe_n ? oe_age + 1 : 0;
      if (!mem_oe_n && mem_we_n) begin
        mdrv = 1'b1;
        if (oe_age >= R && a_age >= (pg ? P : R))
          mval = cfg_wide ? rd16(int'(mem_addr)) : {8'hEE, rd8(int'(mem_addr))};
        else
          mval = 16'hDEAD;
      end else begin
        mdrv = 1'b0;
      end
      pa = mem_addr; poe = mem_oe_n; pwe = mem_we_n;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic set_cfg(bit wide, int f, int r, int p);
    @(negedge clk);
    cfg_wide = wide; cfg_float = 2'(f - 1); cfg_rand = 4'(r - 1); cfg_page = 3'(p - 1);
    F = f; R = r; P = p;
  endtask

  task automatic issue(bit wr, logic [AW-1:0] a, int len, logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = 4'(len); req_wdata = wd;
    chk("R10", "ready before accept", req_ready, 1);
    @(posedge clk);
  endtask

  task automatic do_read(logic [AW-1:0] a, int len);
    int ts[$]; int vt[$]; logic [15:0] vw[$]; logic [AW-1:0] ba[$];
    logic [AW-1:0] prev = '0;
    int t = 0;
    int n = cfg_wide ? len + 1 : 2 * (len + 1);
    int endc;
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] w = cfg_wide ? a + AW'(i) : a + AW'(i / 2);
      logic [AW-1:0] bus = cfg_wide ? w : {w[AW-2:0], 1'(i % 2)};
      ts.push_back(t);
      t += (i == 0 || bus[AW-1:2] != prev[AW-1:2]) ? R : P;
      ba.push_back(bus);
      if (cfg_wide || (i % 2) == 1) begin
        vt.push_back(t);
        vw.push_back(exp_word(int'(w)));
      end
      prev = bus;
    end
    endc = t + F;
    issue(1'b0, a, len, 16'h0);
    for (int j = 0; j <= endc; j++) begin
      int k = 0;
      bit ev;
      @(negedge clk);
      if (j == 0) req_valid = 1'b0;
      chk("R5", "ready after read", req_ready, (j == endc) ? 1 : 0);
      ev = (vt.size() > 0) && (vt[0] == j);
      chk("R2,R3,R4", "rd_valid timing", rd_valid, ev ? 1 : 0);
      if (ev) begin
        chk(cfg_wide ? "R2" : "R7", "read word", rd_data, vw[0]);
        chk("R3", "rd_last", rd_last, (vt.size() == 1) ? 1 : 0);
        void'(vt.pop_front());
        void'(vw.pop_front());
      end
      for (int i = 0; i < n; i++) if (ts[i] <= j) k = i;
      chk("R9", "read address", mem_addr, ba[k]);
      chk("R3", "oe across burst", mem_oe_n, (j >= t) ? 1 : 0);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [15:0] d);
    int n = cfg_wide ? 1 : 2;
    int seg = R + 1 + F;
    int endc = n * seg;
    issue(1'b1, a, 0, d);
    for (int j = 0; j <= endc; j++) begin
      int k = j / seg;
      int o = j % seg;
      @(negedge clk);
      if (j == 0) req_valid = 1'b0;
      chk("R5", "ready after write", req_ready, (j == endc) ? 1 : 0);
      chk("R6", "we strobe", mem_we_n, (j < endc && o < R) ? 0 : 1);
      chk("R6", "oe during write", mem_oe_n, 1);
      if (k >= n) k = n - 1;
      chk("R7", "write address", mem_addr, cfg_wide ? a : {a[AW-2:0], 1'(k)});
      if (j < endc && o == R)
        chk("R6", "data held after strobe", mem_data,
            cfg_wide ? d : {8'h00, (k == 0) ? d[7:0] : d[15:8]});
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R10 watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset ready", req_ready, 1);
    chk("R1", "reset rd_valid", rd_valid, 0);
    chk("R1", "reset oe", mem_oe_n, 1);
    chk("R1", "reset we", mem_we_n, 1);

    set_cfg(1'b1, 2, 3, 2);
    do_read(26'h100, 0);
    do_read(26'h101, 5);
    do_write(26'h200, 16'h1234);
    do_read(26'h1FF, 2);

    set_cfg(1'b1, 1, 1, 1);
    do_read(26'h300, 3);
    set_cfg(1'b1, 1, 1, 4);
    do_read(26'h302, 3);
    set_cfg(1'b1, 4, 16, 8);
    do_read(26'h3FE, 2);
    do_write(26'h3FF, 16'hA55A);
    do_read(26'h3FF, 0);

    set_cfg(1'b0, 2, 3, 2);
    do_write(26'h40, 16'hBEEF);
    do_read(26'h3F, 2);
    set_cfg(1'b0, 1, 2, 1);
    do_read(26'h42, 1);

    @(negedge clk);
    hiz_n = 1'b0; probe = 1'b1;
    @(negedge clk);
    chk("R8", "addr floated", mem_addr, 26'h2A5A5A5);
    chk("R8", "oe floated", mem_oe_n, 0);
    chk("R8", "we floated", mem_we_n, 0);
    chk("R8", "data floated", mem_data, 16'h3C3C);
    probe = 1'b0; hiz_n = 1'b1;
    @(negedge clk);
    chk("R8", "oe driven again", mem_oe_n, 1);
    set_cfg(1'b1, 2, 2, 1);
    do_read(26'h5, 1);

    finish_run();
  end
endmodule